// File: doc/BRIEF.md
# SPI Register Target with In-Band Wait States

This block is an SPI target that carries variable-length register transactions from a host. The bus runs in mode 0 (clock idle low, data captured on the rising edge, changed on the falling edge) with 8-bit words, most significant bit first. Each transaction opens with a four-byte header. The header gives the direction, a payload length of 1 to 64 bytes and a 24-bit register address. The header is followed by a flow-control phase and then by the payload.

The target holds off the payload with an in-band wait. The last header response byte tells the host that a wait is in progress. The host then clocks single poll bytes until the target answers that it is ready. The release comes from a backend-ready input. The payload moves between the bus and a 64-byte internal buffer. The backend reaches the same buffer through its own read/write port. A one-cycle strobe reports each decoded header, and a second strobe reports each completed write payload.

SCK, chip select and MOSI are synchronised into the system clock. That clock must run at least four times the SCK rate. Raising chip select in the middle of a transaction abandons it.

Top module: `spi_flowctl_target`

## Requirements
- R1: After reset, spi_miso is 1, and req_valid and wr_done are 0.
- R2: While spi_cs_n is high, spi_miso is held at 1. The line is driven and never floats.
- R3: During the four header bytes, the bytes returned on spi_miso are 0xFF, 0xFF, 0xFF, 0xFE. The cleared bit 0 of the last byte signals that a wait state has been inserted.
- R4: Header decode works as follows. In header byte 0, bit 7 = 1 means a read and 0 means a write, and bits 5:0 hold the length minus one. Header bytes 1, 2 and 3 form req_addr[23:16], [15:8] and [7:0]. After the fourth header byte, req_valid pulses for exactly one cycle. At that point req_read and req_len (1..64) hold the decoded values.
- R5: The target samples be_ready only when a byte completes: at the end of the last header byte and at the end of each poll byte. A poll byte returns 0x00 while the last sample was low. The poll byte that follows a high sample returns 0x01.
- R6: The byte after the 0x01 poll starts the payload. On a write, payload byte k is stored at buffer index k, and spi_miso returns 0xFF. When the last byte completes, wr_done pulses for one cycle, with req_addr and req_len still valid.
- R7: On a read, payload byte k on spi_miso is the content of buffer index k. MOSI is ignored: the buffer is not changed and wr_done does not pulse.
- R8: Exactly req_len payload bytes are transferred. The target then expects a new header without chip select being raised, so the next bytes return 0xFF, 0xFF, 0xFF, 0xFE.
- R9: Raising spi_cs_n in the middle of a transaction abandons it. The next assertion starts with header byte 0.
- R10: The length limits work: a header length field of 0 moves one byte, and 63 moves 64 bytes.
- R11: Every byte is shifted MSB first in SPI mode 0, and the bit count restarts at each byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Host-to-target data |
| spi_miso | output | 1 | Target-to-host data, registered |
| be_ready | input | 1 | Backend ready; releases the wait |
| req_valid | output | 1 | One-cycle strobe: header decoded |
| req_read | output | 1 | Decoded direction, 1 = read |
| req_addr | output | 24 | Decoded register address |
| req_len | output | 7 | Decoded payload length, 1..64 |
| wr_done | output | 1 | One-cycle strobe: write payload stored |
| bk_we | input | 1 | Backend buffer write enable |
| bk_idx | input | 6 | Backend buffer index |
| bk_wdata | input | 8 | Backend buffer write data |
| bk_rdata | output | 8 | Backend buffer read data, one cycle after bk_idx |

## Verification
The assertions check several rules on every cycle:
- MISO stays high whenever chip select is inactive.
- The bit counter restarts at each byte boundary.
- A poll byte that ends with no ready sample keeps the target in the wait.
- The payload counter never passes the decoded length.
- The header strobe never lasts more than one cycle.
- A chip select release always brings the control back to header byte 0.

Some behaviours only the bench scenarios can show. These are:
- the exact response bytes (FF FF FF FE, 00 polls, then 01);
- the byte-by-byte payload contents in both directions;
- MOSI being ignored on reads;
- the one-byte and 64-byte length limits;
- back-to-back headers under one chip select;
- recovery after a mid-header abort.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int HDR_BYTES  = 4;
  localparam int ADDR_W     = 8 * (HDR_BYTES - 1);
  localparam int MAX_LEN    = 64;
  localparam int IDX_W      = $clog2(MAX_LEN);
  localparam int LEN_W      = IDX_W + 1;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] HDR_RESP  = 8'hFF;
  localparam logic [7:0] WAIT_FLAG = 8'hFE;
  localparam logic [7:0] POLL_HOLD = 8'h00;
  localparam logic [7:0] POLL_GO   = 8'h01;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_POLL = 2'd1,
    ST_DATA = 2'd2
  } sft_state_e;
endpackage

// File: rtl/sft_sync.sv
module sft_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       cs_act,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic       sck_d;
  logic       cs_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [6:0] tx_sh;
  logic       rise, fall, start;

  assign rise  = cs_act & sck_s & ~sck_d;
  assign fall  = cs_act & ~sck_s & sck_d;
  assign start = cs_act & ~cs_d;

  assign byte_done = rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      cs_d    <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      miso    <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_act;
      if (!cs_act) begin
        bit_cnt <= '0;
        tx_sh   <= '1;
        miso    <= 1'b1;
      end else if (start) begin
        tx_sh <= tx_byte[6:0];
        miso  <= tx_byte[7];
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (fall) begin
          if (bit_cnt == 3'd0) begin
            tx_sh <= tx_byte[6:0];
            miso  <= tx_byte[7];
          end else begin
            tx_sh <= {tx_sh[5:0], 1'b1};
            miso  <= tx_sh[6];
          end
        end
      end
    end
  end

  AST_MISO_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> miso) else $error("miso not high while deselected"); // R2
  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (bit_cnt == 3'd0)) else $error("bit count did not wrap"); // R11
endmodule

// File: rtl/sft_buf.sv
module sft_buf #(
  parameter int DEPTH = 64,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_idx,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_idx,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_idx] <= b_wdata;
    if (a_we) mem[a_idx] <= a_wdata;
    a_rdata <= mem[a_idx];
    b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              be_ready,
  input  logic [7:0]        buf_rdata,
  output logic [7:0]        tx_byte,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic              req_valid,
  output logic              req_read,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              wr_done
);
  sft_state_e       state;
  logic [1:0]       hdr_idx;
  logic             go;
  logic [IDX_W-1:0] data_cnt;
  logic [IDX_W-1:0] len_m1;
  logic             rd_flag;

  assign req_read  = rd_flag;
  assign req_len   = {1'b0, len_m1} + LEN_W'(1);
  assign buf_idx   = data_cnt;
  assign buf_wdata = rx_byte;
  assign buf_we    = byte_done && (state == ST_DATA) && !rd_flag;

  always_comb begin
    unique case (state)
      ST_HDR:  tx_byte = (hdr_idx == 2'(HDR_BYTES - 1)) ? WAIT_FLAG : HDR_RESP;
      ST_POLL: tx_byte = go ? POLL_GO : POLL_HOLD;
      ST_DATA: tx_byte = rd_flag ? buf_rdata : FILL_BYTE;
      default: tx_byte = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HDR;
      hdr_idx   <= '0;
      go        <= 1'b0;
      data_cnt  <= '0;
      len_m1    <= '0;
      rd_flag   <= 1'b0;
      req_addr  <= '0;
      req_valid <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      wr_done   <= 1'b0;
      if (!cs_act) begin
        state    <= ST_HDR;
        hdr_idx  <= '0;
        go       <= 1'b0;
        data_cnt <= '0;
      end else if (byte_done) begin
        unique case (state)
          ST_HDR: begin
            if (hdr_idx == 2'd0) begin
              rd_flag <= rx_byte[7];
              len_m1  <= rx_byte[IDX_W-1:0];
            end else begin
              req_addr <= {req_addr[ADDR_W-9:0], rx_byte};
            end
            hdr_idx <= hdr_idx + 2'd1;
            if (hdr_idx == 2'(HDR_BYTES - 1)) begin
              state     <= ST_POLL;
              go        <= be_ready;
              req_valid <= 1'b1;
            end
          end
          ST_POLL: begin
            if (go) begin
              state    <= ST_DATA;
              data_cnt <= '0;
            end else begin
              go <= be_ready;
            end
          end
          ST_DATA: begin
            if (data_cnt == len_m1) begin
              state    <= ST_HDR;
              hdr_idx  <= '0;
              go       <= 1'b0;
              data_cnt <= '0;
              wr_done  <= !rd_flag;
            end else begin
              data_cnt <= data_cnt + IDX_W'(1);
            end
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  AST_POLL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_act && byte_done && state == ST_POLL && !go) |=> (state == ST_POLL))
    else $error("left wait without a ready sample"); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (data_cnt <= len_m1))
    else $error("payload counter past length"); // R8
  AST_HDR_STROBE_ONCE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid) else $error("header strobe too long"); // R4
  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (state == ST_HDR && hdr_idx == 2'd0))
    else $error("no restart after deselect"); // R9
endmodule

// File: rtl/spi_flowctl_target.sv
module spi_flowctl_target
  import sft_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              be_ready,
  output logic              req_valid,
  output logic              req_read,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              wr_done,
  input  logic              bk_we,
  input  logic [IDX_W-1:0]  bk_idx,
  input  logic [7:0]        bk_wdata,
  output logic [7:0]        bk_rdata
);
  logic [2:0]       pins_s;
  logic             sck_s, cs_act, mosi_s;
  logic             byte_done;
  logic [7:0]       rx_byte, tx_byte;
  logic [IDX_W-1:0] buf_idx;
  logic             buf_we;
  logic [7:0]       buf_wdata, buf_rdata;

  sft_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );

  assign sck_s  = pins_s[2];
  assign cs_act = ~pins_s[1];
  assign mosi_s = pins_s[0];

  sft_shifter u_shift (
    .clk(clk), .rst(rst),
    .sck_s(sck_s), .cs_act(cs_act), .mosi_s(mosi_s),
    .tx_byte(tx_byte),
    .miso(spi_miso), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  sft_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cs_act(cs_act), .byte_done(byte_done), .rx_byte(rx_byte),
    .be_ready(be_ready), .buf_rdata(buf_rdata),
    .tx_byte(tx_byte),
    .buf_idx(buf_idx), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len), .wr_done(wr_done)
  );

  sft_buf #(.DEPTH(MAX_LEN), .W(8)) u_buf (
    .clk(clk),
    .a_we(buf_we), .a_idx(buf_idx), .a_wdata(buf_wdata), .a_rdata(buf_rdata),
    .b_we(bk_we), .b_idx(bk_idx), .b_wdata(bk_wdata), .b_rdata(bk_rdata)
  );

  AST_DONE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> !req_read) else $error("write strobe on a read"); // R7
endmodule

// File: tb/spi_flowctl_target_test.sv
module spi_flowctl_target_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic        be_ready = 1'b0;
  logic        req_valid, req_read, wr_done;
  logic [23:0] req_addr;
  logic [6:0]  req_len;
  logic        bk_we = 1'b0;
  logic [5:0]  bk_idx = '0;
  logic [7:0]  bk_wdata = '0;
  logic [7:0]  bk_rdata;

  int checks = 0, errors = 0;
  int n_valid = 0, n_done = 0;
  logic [23:0] done_addr;
  logic [6:0]  done_len;
  logic [7:0]  model [64];

  always #5 clk = ~clk;

  spi_flowctl_target uut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .be_ready(be_ready),
    .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
    .req_len(req_len), .wr_done(wr_done), .bk_we(bk_we), .bk_idx(bk_idx),
    .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
  );

  always @(negedge clk) begin
    if (!rst && req_valid) n_valid++;
    if (!rst && wr_done) begin
      n_done++;
      done_addr = req_addr;
      done_len  = req_len;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) spi_mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (5) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic header(input bit rd, input int len, input logic [23:0] addr, input string req);
    logic [7:0] hb [4];
    logic [7:0] exp, rx;
    hb[0] = {rd, 1'b0, 6'(len - 1)};
    hb[1] = addr[23:16]; hb[2] = addr[15:8]; hb[3] = addr[7:0];
    for (int i = 0; i < 4; i++) begin
      xfer(hb[i], rx);
      exp = (i == 3) ? 8'hFE : 8'hFF;
      chk(rx == exp, req, rx, exp);
    end
  endtask

  task automatic poll_go(input string req);
    logic [7:0] rx;
    xfer(8'h00, rx);
    chk(rx == 8'h01, req, rx, 8'h01);
  endtask

  task automatic bk_read(input int idx, output logic [7:0] d);
    @(negedge clk) bk_idx = 6'(idx);
    @(negedge clk) d = bk_rdata;
  endtask

  task automatic bk_write(input int idx, input logic [7:0] d);
    @(negedge clk) begin bk_idx = 6'(idx); bk_wdata = d; bk_we = 1'b1; end
    @(negedge clk) bk_we = 1'b0;
  endtask

  task automatic t_reset();
    chk(spi_miso == 1'b1, "R1 miso", spi_miso, 1);
    chk(req_valid == 1'b0 && wr_done == 1'b0, "R1 strobes", {req_valid, wr_done}, 0);
  endtask

  task automatic t_write(input int len, input logic [23:0] addr, input logic [7:0] base, input string req);
    logic [7:0] rx, d;
    int v0 = n_valid, d0 = n_done;
    be_ready = 1'b1;
    cs_on();
    header(1'b0, len, addr, "R3 write header");
    chk(n_valid == v0 + 1 && req_read == 1'b0 && req_len == 7'(len) && req_addr == addr,
        "R4 decode", {req_read, req_len}, len);
    poll_go("R5 ready early");
    for (int k = 0; k < len; k++) begin
      d = base ^ 8'(k * 37 + 5);
      model[k] = d;
      xfer(d, rx);
      chk(rx == 8'hFF, "R6 filler", rx, 8'hFF);
    end
    cs_off();
    be_ready = 1'b0;
    chk(n_done == d0 + 1, {req, " done strobe"}, n_done - d0, 1);
    chk(done_addr == addr && done_len == 7'(len), "R6 done fields", done_len, len);
    for (int k = 0; k < len; k++) begin
      bk_read(k, d);
      chk(d == model[k], {req, " stored"}, d, model[k]);
    end
  endtask

  task automatic t_read(input int len, input logic [23:0] addr, input string req);
    logic [7:0] rx, d;
    int d0 = n_done;
    for (int k = 0; k < len; k++) begin
      model[k] = 8'(k * 11 + 8'h5A);
      bk_write(k, model[k]);
    end
    be_ready = 1'b1;
    cs_on();
    header(1'b1, len, addr, "R3 read header");
    chk(req_read == 1'b1 && req_len == 7'(len) && req_addr == addr, "R4 read decode", req_len, len);
    poll_go("R5 ready early");
    for (int k = 0; k < len; k++) begin
      xfer(8'($urandom), rx);
      chk(rx == model[k], {req, " payload"}, rx, model[k]);
    end
    cs_off();
    be_ready = 1'b0;
    chk(n_done == d0, "R7 no done strobe", n_done - d0, 0);
    for (int k = 0; k < len; k++) begin
      bk_read(k, d);
      chk(d == model[k], "R7 buffer untouched", d, model[k]);
    end
  endtask

  task automatic t_wait();
    logic [7:0] rx;
    be_ready = 1'b0;
    cs_on();
    header(1'b0, 2, 24'h00ABCD, "R3 header");
    xfer(8'h00, rx); chk(rx == 8'h00, "R5 hold 1", rx, 0);
    xfer(8'h00, rx); chk(rx == 8'h00, "R5 hold 2", rx, 0);
    be_ready = 1'b1;
    xfer(8'h00, rx); chk(rx == 8'h00, "R5 sampled at boundary", rx, 0);
    xfer(8'h00, rx); chk(rx == 8'h01, "R5 release", rx, 1);
    xfer(8'hC3, rx); xfer(8'h3C, rx);
    // R8: next bytes under the same select form a new header
    header(1'b1, 1, 24'h000001, "R8 back-to-back header");
    cs_off();
    be_ready = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    int v0 = n_valid;
    cs_on();
    xfer(8'h85, rx); xfer(8'h12, rx);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(spi_miso == 1'b1, "R2 miso idle high", spi_miso, 1);
    repeat (4) @(negedge clk);
    chk(spi_miso == 1'b1, "R2 miso stays high", spi_miso, 1);
    cs_on();
    header(1'b0, 3, 24'h777777, "R9 restart header");
    chk(n_valid == v0 + 1, "R9 single header strobe", n_valid - v0, 1);
    cs_off();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(8, 24'h123456, 8'h11, "R6 write");
    t_read(5, 24'hFEDC01, "R7 read");
    t_wait();
    t_abort();
    t_write(64, 24'h0000F0, 8'hA5, "R10 write 64");
    t_read(1, 24'h808080, "R10 read 1");
    t_read(64, 24'h010203, "R11 read 64");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule